// File: doc/BRIEF.md
# Lane-Group Burst Coalescer

This unit sits between a 16-lane load/store issue stage and an external memory port. Each input transfer carries one address per lane, a per-lane active mask and a common per-lane access size in bytes. The unit decides whether the active lanes can be served by one aligned, contiguous burst. If they can, it emits one burst request. Otherwise it emits one request per active lane, one per accepted handshake.

A group qualifies for a burst only under three conditions. The size must be 4, 8 or 16 bytes. The burst base must be a multiple of sixteen times the size. Every active lane k must address element k after that base. Inactive lanes are ignored. An empty group is accepted and dropped.

A three-state controller sequences the work. `ST_IDLE` takes a group: an empty mask stays in `ST_IDLE`, a qualifying group goes to `ST_BURST`, and any other group goes to `ST_SINGLE`. `ST_BURST` returns to `ST_IDLE` when its request is accepted. `ST_SINGLE` stays in place while active lanes are still pending and returns to `ST_IDLE` once the last one is accepted.

Top module: `coal_unit`

## Requirements
- R1: After reset `in_ready` is 1 and `req_valid` is 0.
- R2: A group whose `in_size` is not 4, 8 or 16 is never issued as a burst.
- R3: A group is issued as a burst only if its base is a multiple of 16 × `in_size`. The base is the first active lane's address minus its lane index times `in_size`.
- R4: A group is issued as a burst only if every active lane k addresses base + k × `in_size`. Swapped or strided lanes force per-lane requests.
- R5: Lanes whose `in_mask` bit is 0 may hold any address without preventing a burst.
- R6: A burst request has `req_burst`=1, `req_addr`=base, `req_len`=16 × `in_size` and `req_mask` equal to the group's `in_mask` (bit k is lane k).
- R7: Per-lane requests have `req_burst`=0 and are issued in ascending lane order, one per active lane. Each has `req_addr` equal to that lane's address, `req_len`=`in_size`, and `req_mask` one-hot at the lane index.
- R8: `in_ready` stays 0 until every request of the current group has been accepted (`req_valid` and `req_ready` both high at a clock edge). While a request waits, its fields stay stable.
- R9: A group with an all-zero `in_mask` produces no request, and `in_ready` is 1 again in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Group offered |
| in_ready | output | 1 | Group accepted when high together with in_valid |
| in_addr | input | 512 | Lane addresses, lane k at bits [32k+31:32k] |
| in_mask | input | 16 | Active lanes, bit k is lane k |
| in_size | input | 5 | Per-lane access size in bytes |
| req_valid | output | 1 | Memory request present |
| req_ready | input | 1 | Memory port accepts request |
| req_burst | output | 1 | 1 for a burst, 0 for a single-lane request |
| req_addr | output | 32 | Request byte address |
| req_len | output | 9 | Request length in bytes |
| req_mask | output | 16 | Element mask (burst) or one-hot lane (single) |

## Verification
The bench sweeps sizes 4, 8, 16, 12, 2 and 0. Each size is tried against three base offsets: aligned, off by one element, and off by 64 bytes. The last offset is aligned for 4-byte lanes but not for wider ones. Lane layouts cover contiguous, two swapped lanes, doubled stride, all lanes on one address, and one stray lane. These are crossed with full, empty, single-end and sparse masks. The stray-lane layout shows whether masking hides a bad address. The offsets and swaps separate the alignment rule from the ordering rule. Periodic back-pressure on `req_ready` exercises hold and ordering of per-lane requests.

// File: rtl/coal_pkg.sv
package coal_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_BURST  = 2'd1,
        ST_SINGLE = 2'd2
    } coal_state_e;
endpackage

// File: rtl/coal_check.sv
// Decides whether a lane group maps onto one aligned contiguous burst.
module coal_check #(
    parameter int LANES  = 16,
    parameter int ADDR_W = 32,
    parameter int SIZE_W = 5
) (
    input  logic [LANES*ADDR_W-1:0] addr,
    input  logic [LANES-1:0]        mask,
    input  logic [SIZE_W-1:0]       size,
    output logic                    ok,
    output logic [ADDR_W-1:0]       base
);
    localparam int LANE_BITS = $clog2(LANES);

    logic [ADDR_W-1:0]    size_w;
    logic [ADDR_W-1:0]    span;
    logic [ADDR_W-1:0]    first_addr;
    logic                 size_ok;
    logic [LANES-1:0]     lane_ok;

    assign size_w  = ADDR_W'(size);
    assign span    = size_w << LANE_BITS;
    assign size_ok = (size == SIZE_W'(4)) || (size == SIZE_W'(8)) || (size == SIZE_W'(16));

    always_comb begin
        first_addr = '0;
        for (int k = LANES - 1; k >= 0; k--) begin
            if (mask[k]) first_addr = addr[k*ADDR_W +: ADDR_W];
        end
    end

    assign base = first_addr & ~(span - ADDR_W'(1));

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_lane
            assign lane_ok[g] = !mask[g] ||
                (addr[g*ADDR_W +: ADDR_W] == base + ADDR_W'(g) * size_w);
        end
    endgenerate

    assign ok = size_ok && (|mask) && (&lane_ok);
endmodule

// File: rtl/coal_pick.sv
// Finds the lowest pending lane.
module coal_pick #(
    parameter int LANES = 16
) (
    input  logic [LANES-1:0]         pend,
    output logic [$clog2(LANES)-1:0] idx,
    output logic [LANES-1:0]         onehot
);
    localparam int LANE_BITS = $clog2(LANES);

    always_comb begin
        idx = '0;
        for (int k = LANES - 1; k >= 0; k--) begin
            if (pend[k]) idx = LANE_BITS'(k);
        end
        onehot = pend & (~pend + LANES'(1));
    end
endmodule

// File: rtl/coal_unit.sv
module coal_unit #(
    parameter int LANES  = 16,
    parameter int ADDR_W = 32,
    parameter int SIZE_W = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic [LANES*ADDR_W-1:0] in_addr,
    input  logic [LANES-1:0]        in_mask,
    input  logic [SIZE_W-1:0]       in_size,
    output logic                    req_valid,
    input  logic                    req_ready,
    output logic                    req_burst,
    output logic [ADDR_W-1:0]       req_addr,
    output logic [SIZE_W+$clog2(LANES)-1:0] req_len,
    output logic [LANES-1:0]        req_mask
);
    import coal_pkg::*;

    localparam int LANE_BITS = $clog2(LANES);
    localparam int LEN_W     = SIZE_W + LANE_BITS;

    coal_state_e state_q, state_d;

    logic [LANES*ADDR_W-1:0] addr_q;
    logic [LANES-1:0]        mask_q;
    logic [LANES-1:0]        pend_q;
    logic [SIZE_W-1:0]       size_q;
    logic [ADDR_W-1:0]       base_q;

    logic                    chk_ok;
    logic [ADDR_W-1:0]       chk_base;
    logic [LANE_BITS-1:0]    pick_idx;
    logic [LANES-1:0]        pick_hot;
    logic                    take;
    logic                    fire;
    logic                    last_single;

    coal_check #(.LANES(LANES), .ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_check (
        .addr (in_addr),
        .mask (in_mask),
        .size (in_size),
        .ok   (chk_ok),
        .base (chk_base)
    );

    coal_pick #(.LANES(LANES)) u_pick (
        .pend   (pend_q),
        .idx    (pick_idx),
        .onehot (pick_hot)
    );

    assign take        = in_valid && in_ready;
    assign fire        = req_valid && req_ready;
    assign last_single = (pend_q & ~pick_hot) == '0;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (take && (|in_mask)) state_d = chk_ok ? ST_BURST : ST_SINGLE;
            end
            ST_BURST: begin
                if (fire) state_d = ST_IDLE;
            end
            ST_SINGLE: begin
                if (fire && last_single) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // group capture and pending-lane bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            mask_q <= '0;
            pend_q <= '0;
            size_q <= '0;
            base_q <= '0;
        end else if (take) begin
            addr_q <= in_addr;
            mask_q <= in_mask;
            pend_q <= in_mask;
            size_q <= in_size;
            base_q <= chk_base;
        end else if (state_q == ST_SINGLE && fire) begin
            pend_q <= pend_q & ~pick_hot;
        end
    end

    // outputs
    always_comb begin
        in_ready  = 1'b0;
        req_valid = 1'b0;
        req_burst = 1'b0;
        req_addr  = '0;
        req_len   = '0;
        req_mask  = '0;
        unique case (state_q)
            ST_IDLE: begin
                in_ready = 1'b1;
            end
            ST_BURST: begin
                req_valid = 1'b1;
                req_burst = 1'b1;
                req_addr  = base_q;
                req_len   = LEN_W'(size_q) << LANE_BITS;
                req_mask  = mask_q;
            end
            ST_SINGLE: begin
                req_valid = 1'b1;
                req_addr  = addr_q[pick_idx*ADDR_W +: ADDR_W];
                req_len   = LEN_W'(size_q);
                req_mask  = pick_hot;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/coal_unit_chk.sv
module coal_unit_chk #(
    parameter int LANES  = 16,
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_ready,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_burst,
    input logic [ADDR_W-1:0] req_addr,
    input logic [LEN_W-1:0]  req_len,
    input logic [LANES-1:0]  req_mask
);
    localparam int B4  = LANES * 4;
    localparam int B8  = LANES * 8;
    localparam int B16 = LANES * 16;

    p_busy_blocks_input_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> !in_ready);

    p_hold_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) &&
            $stable(req_len) && $stable(req_mask) && $stable(req_burst)));

    p_single_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_burst) |-> ($countones(req_mask) == 1));

    p_burst_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_burst) |->
            (req_len == LEN_W'(B4) || req_len == LEN_W'(B8) || req_len == LEN_W'(B16)));

    p_burst_align_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_burst) |->
            ((req_addr & (ADDR_W'(req_len) - ADDR_W'(1))) == '0));

    p_burst_nonempty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_burst) |-> (req_mask != '0));
endmodule

bind coal_unit coal_unit_chk #(
    .LANES  (LANES),
    .ADDR_W (ADDR_W),
    .LEN_W  (SIZE_W + $clog2(LANES))
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_ready  (in_ready),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_burst (req_burst),
    .req_addr  (req_addr),
    .req_len   (req_len),
    .req_mask  (req_mask)
);

// File: tb/sim_coal_unit.sv
module sim_coal_unit;
    localparam int CLK_PERIOD = 10;
    localparam int LANES  = 16;
    localparam int ADDR_W = 32;
    localparam int SIZE_W = 5;
    localparam int LEN_W  = 9;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    in_valid = 1'b0;
    logic                    in_ready;
    logic [LANES*ADDR_W-1:0] in_addr = '0;
    logic [LANES-1:0]        in_mask = '0;
    logic [SIZE_W-1:0]       in_size = '0;
    logic                    req_valid;
    logic                    req_ready = 1'b0;
    logic                    req_burst;
    logic [ADDR_W-1:0]       req_addr;
    logic [LEN_W-1:0]        req_len;
    logic [LANES-1:0]        req_mask;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    coal_unit #(.LANES(LANES), .ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_addr(in_addr), .in_mask(in_mask), .in_size(in_size),
        .req_valid(req_valid), .req_ready(req_ready), .req_burst(req_burst),
        .req_addr(req_addr), .req_len(req_len), .req_mask(req_mask)
    );

    // expected request list
    logic [ADDR_W-1:0] e_addr [LANES];
    int                e_len  [LANES];
    logic [LANES-1:0]  e_mask [LANES];
    bit                e_bur  [LANES];
    int                e_cnt;

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic run_group(input int size, input int off, input int mode,
                             input logic [LANES-1:0] mask);
        logic [ADDR_W-1:0] a [LANES];
        logic [ADDR_W-1:0] b0;
        logic [ADDR_W-1:0] bb;
        int    f;
        bit    size_ok, aligned, ordered, coal;
        string tag;
        int    n;
        int    guard;
        bit    rdy;
        b0 = 32'h0000_1000 + ADDR_W'(off);
        for (int k = 0; k < LANES; k++) begin
            case (mode)
                0: a[k] = b0 + ADDR_W'(k * size);
                1: a[k] = b0 + ADDR_W'(((k == 2) ? 3 : (k == 3) ? 2 : k) * size);
                2: a[k] = b0 + ADDR_W'(k * 2 * size);
                3: a[k] = b0;
                default: a[k] = (k == 5) ? b0 + 32'h0004_0000 : b0 + ADDR_W'(k * size);
            endcase
        end
        // independent model of the burst rules (R2, R3, R4, R5)
        size_ok = (size == 4) || (size == 8) || (size == 16);
        f = -1;
        for (int k = LANES - 1; k >= 0; k--) if (mask[k]) f = k;
        bb = '0;
        aligned = 1'b0;
        ordered = 1'b1;
        if (f >= 0 && size_ok) begin
            bb = a[f] - ADDR_W'(f * size);
            aligned = (bb % (16 * size)) == 0;
            for (int k = 0; k < LANES; k++)
                if (mask[k] && a[k] != bb + ADDR_W'(k * size)) ordered = 1'b0;
        end
        coal = (f >= 0) && size_ok && aligned && ordered;
        if (!size_ok)               tag = "R2";
        else if (f >= 0 && !aligned) tag = "R3";
        else if (!ordered)          tag = "R4";
        else if (mask != '1)        tag = "R5";
        else                        tag = "R6";
        e_cnt = 0;
        if (coal) begin
            e_addr[0] = bb; e_len[0] = 16 * size; e_mask[0] = mask; e_bur[0] = 1'b1;
            e_cnt = 1;
        end else begin
            for (int k = 0; k < LANES; k++) begin
                if (mask[k]) begin
                    e_addr[e_cnt] = a[k];
                    e_len[e_cnt]  = size;
                    e_mask[e_cnt] = LANES'(1) << k;
                    e_bur[e_cnt]  = 1'b0;
                    e_cnt++;
                end
            end
        end
        // drive the group
        @(negedge clk);
        for (int k = 0; k < LANES; k++) in_addr[k*ADDR_W +: ADDR_W] = a[k];
        in_mask  = mask;
        in_size  = SIZE_W'(size);
        in_valid = 1'b1;
        guard = 0;
        while (!in_ready && guard < 100) begin @(negedge clk); guard++; end
        @(negedge clk);
        in_valid = 1'b0;
        // collect requests with periodic back-pressure
        n = 0;
        guard = 0;
        while (n < e_cnt && guard < 200) begin
            rdy = (cyc % 3) != 1;
            req_ready = rdy;
            #1;
            check(!in_ready, "R8", "in_ready while busy", in_ready, 0);
            if (req_valid && rdy) begin
                check(req_burst == e_bur[n] && req_addr == e_addr[n] &&
                      int'(req_len) == e_len[n] && req_mask == e_mask[n],
                      (n == 0) ? tag : "R7",
                      coal ? "burst R6 fields" : "single R7 fields",
                      {req_burst, req_addr, 7'(req_len), req_mask},
                      {e_bur[n], e_addr[n], 7'(e_len[n]), e_mask[n]});
                n++;
            end
            @(negedge clk);
            guard++;
            cyc++;
        end
        req_ready = 1'b0;
        if (n < e_cnt) check(1'b0, "R7", "request count", n, e_cnt);
        #1;
        check(in_ready && !req_valid, (e_cnt == 0) ? "R9" : "R8",
              "idle after group", {in_ready, req_valid}, 2'b10);
    endtask

    int sizes [6] = '{4, 8, 16, 12, 2, 0};
    logic [LANES-1:0] masks [6] = '{16'hFFFF, 16'h0000, 16'h0001, 16'h8000, 16'hA5A5, 16'h7FFE};

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(in_ready && !req_valid, "R1", "reset state", {in_ready, req_valid}, 2'b10);
        rst_n = 1'b1;
        @(negedge clk);
        check(in_ready && !req_valid, "R1", "after reset", {in_ready, req_valid}, 2'b10);
        for (int si = 0; si < 6; si++) begin
            for (int oi = 0; oi < 3; oi++) begin
                for (int md = 0; md < 5; md++) begin
                    for (int mi = 0; mi < 6; mi++) begin
                        int off;
                        off = (oi == 0) ? 0 : (oi == 1) ? sizes[si] : 64;
                        run_group(sizes[si], off, md, masks[mi]);
                    end
                end
            end
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        int wd;
        wd = 0;
        while (wd < 190000) begin @(posedge clk); wd++; end
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", wd, 0);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule